// File: doc/BRIEF.md
# Two-Stage Redundant-Path Switching Network

This block moves packets from eight inputs to eight outputs through two ranks of 4x4 crossbar boxes. Each node index is three binary coordinates. A first-rank box settles the lowest input coordinate pair and the middle destination coordinate at once. A second-rank box settles the top and bottom destination coordinates. Both ranks use all four ports of every box. One of the first-rank output coordinates is not part of the address. It is a free binary path index, so every input-output pair has two distinct routes through the network.

Each input presents at most one packet per cycle, with a 3-bit destination and a payload. The path index is taken from a per-input select bit when that input's enable is high. Otherwise it comes from a free-running pseudo-random generator, or from the inverse of the previous attempt when the previous attempt was blocked. Every box grants contested outputs to its lowest-numbered requesting port. Losers in the first rank are reported back to the source so that it can retry. Losers in the second rank are reported as dropped.

Top module: `mpn_net`

## Requirements
- R1: After synchronous reset, `out_valid`, `in_blocked` and `out_drop` are all zero.
- R2: A packet at input i (index bits {n3,n2,n1} = i[2:0]) with destination d ({m3,m2,m1} = d[2:0]) that meets no contention appears on `out_valid[d]` two clock edges after it is sampled. It carries its payload unchanged and `out_src` equal to i, for either path index.
- R3: At each output edge, the number of delivered packets plus the number of dropped packets equals the number of packets that passed the first rank one edge earlier. No output or flag asserts without a matching packet.
- R4: First-rank box n3 (input bit 2) arbitrates on output port {d[1], path}. When two of its inputs request the same port, the input with the lower {n2,n1} wins. Each loser gets `in_blocked` one edge after sampling and is not delivered.
- R5: Two inputs of the same first-rank box with the same d[1] but different path indices are both delivered.
- R6: Second-rank box d[1] receives on port {path, n3} and sends on port {d[2], d[0]}. When two packets share a destination, the lower port {path, n3} wins. `out_drop[src]` of the loser asserts two edges after sampling.
- R7: When `in_rsel_en[i]` is 1, the path index is `in_rsel[i]`. When it is 0 and no retry is pending, the path index comes from the internal pseudo-random generator, which never reaches the all-zero state.
- R8: Suppose input i was blocked on its previous sampled cycle and presents again with `in_rsel_en[i]` = 0. It then uses the inverse of the path index of that previous attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 8 | Packet present per input |
| in_dest | input | 24 | 3-bit destination per input |
| in_data | input | 8*DATA_W | Payload per input |
| in_rsel_en | input | 8 | Use explicit path index per input |
| in_rsel | input | 8 | Explicit path index per input |
| in_blocked | output | 8 | Input lost first-rank arbitration last edge |
| out_valid | output | 8 | Packet delivered per output |
| out_data | output | 8*DATA_W | Delivered payload per output |
| out_src | output | 24 | Source index of delivered packet |
| out_drop | output | 8 | Packet from this source lost second-rank arbitration |

## Verification
A wrong path index or a miswired inter-rank link sends a packet to the wrong output, or makes it collide where none should occur. Either fault shows at the ports within two edges as a missing or misplaced `out_valid` bit. A corrupted retry flag or last-path register shows one cycle after the retry. A third packet's blocked flag then appears or goes missing, depending on which path the retrying input took. A priority error inverts which source is blocked or dropped in the very cycle the contention resolves.

// File: rtl/mpn_pkg.sv
package mpn_pkg;
  localparam int IDX_W  = 3;            // binary coordinates per node index
  localparam int NODES  = 1 << IDX_W;   // network inputs and outputs
  localparam int BOX_W  = 2;            // coordinates handled per box
  localparam int BOX_N  = 1 << BOX_W;   // ports per box
  localparam int BOXES  = NODES / BOX_N;// boxes per rank
endpackage

// File: rtl/mpn_xbar4.sv
// Combinational crossbar with fixed lowest-port-first arbitration.
module mpn_xbar4 #(
  parameter int P  = 4,
  parameter int PW = 2,
  parameter int W  = 8
) (
  input  logic [P-1:0]    req_v,
  input  logic [P*PW-1:0] req_sel,
  input  logic [P*W-1:0]  req_pl,
  output logic [P-1:0]    gnt_v,
  output logic [P*W-1:0]  gnt_pl,
  output logic [P-1:0]    lose
);
  always_comb begin
    gnt_v  = '0;
    gnt_pl = '0;
    lose   = '0;
    for (int i = 0; i < P; i++) begin
      if (req_v[i]) begin
        if (!gnt_v[req_sel[i*PW +: PW]]) begin
          gnt_v[req_sel[i*PW +: PW]] = 1'b1;
          gnt_pl[int'(req_sel[i*PW +: PW])*W +: W] = req_pl[i*W +: W];
        end else begin
          lose[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mpn_lfsr.sv
// Galois pseudo-random generator supplying default path indices.
module mpn_lfsr #(
  parameter int         W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h1ACE
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= (state >> 1) ^ (state[0] ? TAPS : '0);
  end

  a_r7_lfsr_live: assert property (@(posedge clk) disable iff (rst) state != '0)
    else $error("R7: generator reached zero state");
endmodule

// File: rtl/mpn_net.sv
module mpn_net
  import mpn_pkg::*;
#(
  parameter int             DATA_W    = 8,
  parameter int             LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'h1ACE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NODES-1:0]        in_valid,
  input  logic [NODES*IDX_W-1:0]  in_dest,
  input  logic [NODES*DATA_W-1:0] in_data,
  input  logic [NODES-1:0]        in_rsel_en,
  input  logic [NODES-1:0]        in_rsel,
  output logic [NODES-1:0]        in_blocked,
  output logic [NODES-1:0]        out_valid,
  output logic [NODES*DATA_W-1:0] out_data,
  output logic [NODES*IDX_W-1:0]  out_src,
  output logic [NODES-1:0]        out_drop
);
  // payload = {src, dest, data}
  localparam int PL_W    = DATA_W + 2*IDX_W;
  localparam int DST_LSB = DATA_W;
  localparam int SRC_LSB = DATA_W + IDX_W;

  logic [LFSR_W-1:0]     lfsr_q;
  logic [NODES-1:0]      r_pick, blk_q, last_r_q, s1_lose;
  logic [NODES-1:0]      s1_v_d, s1_v_q, s2_lose, out_v_d, out_v_q, drop_d, drop_q;
  logic [NODES*PL_W-1:0] s1_pl_d, s1_pl_q, out_pl_d, out_pl_q;

  mpn_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state(lfsr_q)
  );

  // path index choice: explicit, retry-flip, or pseudo-random
  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      if (in_rsel_en[i])  r_pick[i] = in_rsel[i];
      else if (blk_q[i])  r_pick[i] = ~last_r_q[i];
      else                r_pick[i] = lfsr_q[i % LFSR_W];
    end
  end

  // first rank: box b holds inputs with n3 = b, port {n2,n1}; out port {m2,r}
  for (genvar b = 0; b < BOXES; b++) begin : g_s1
    logic [BOX_N-1:0]       rv, gv, lz;
    logic [BOX_N*BOX_W-1:0] rs;
    logic [BOX_N*PL_W-1:0]  rp, gp;

    always_comb begin
      for (int p = 0; p < BOX_N; p++) begin
        rv[p]                 = in_valid[b*BOX_N + p];
        rs[p*BOX_W +: BOX_W]  = {in_dest[(b*BOX_N + p)*IDX_W + 1], r_pick[b*BOX_N + p]};
        rp[p*PL_W +: PL_W]    = {IDX_W'(b*BOX_N + p),
                                 in_dest[(b*BOX_N + p)*IDX_W +: IDX_W],
                                 in_data[(b*BOX_N + p)*DATA_W +: DATA_W]};
      end
    end

    mpn_xbar4 #(.P(BOX_N), .PW(BOX_W), .W(PL_W)) u_box (
      .req_v(rv), .req_sel(rs), .req_pl(rp),
      .gnt_v(gv), .gnt_pl(gp), .lose(lz)
    );

    assign s1_lose[b*BOX_N +: BOX_N] = lz;

    // link: out port {m2,r} of box n3 -> second-rank box m2, in port {r,n3}
    for (genvar q = 0; q < BOX_N; q++) begin : g_link
      localparam int SLOT = (q / 2) * BOX_N + (q % 2) * 2 + b;
      assign s1_v_d[SLOT]                = gv[q];
      assign s1_pl_d[SLOT*PL_W +: PL_W]  = gp[q*PL_W +: PL_W];
    end
  end

  // second rank: box m2, in port {r,n3}, out port {m3,m1}
  for (genvar m = 0; m < BOXES; m++) begin : g_s2
    logic [BOX_N-1:0]       rv, gv, lz;
    logic [BOX_N*BOX_W-1:0] rs;
    logic [BOX_N*PL_W-1:0]  rp, gp;

    always_comb begin
      for (int p = 0; p < BOX_N; p++) begin
        rv[p]                = s1_v_q[m*BOX_N + p];
        rp[p*PL_W +: PL_W]   = s1_pl_q[(m*BOX_N + p)*PL_W +: PL_W];
        rs[p*BOX_W +: BOX_W] = {s1_pl_q[(m*BOX_N + p)*PL_W + DST_LSB + 2],
                                s1_pl_q[(m*BOX_N + p)*PL_W + DST_LSB]};
      end
    end

    mpn_xbar4 #(.P(BOX_N), .PW(BOX_W), .W(PL_W)) u_box (
      .req_v(rv), .req_sel(rs), .req_pl(rp),
      .gnt_v(gv), .gnt_pl(gp), .lose(lz)
    );

    assign s2_lose[m*BOX_N +: BOX_N] = lz;

    for (genvar o = 0; o < BOX_N; o++) begin : g_out
      localparam int NODE = (o / 2) * 4 + m * 2 + (o % 2);
      assign out_v_d[NODE]               = gv[o];
      assign out_pl_d[NODE*PL_W +: PL_W] = gp[o*PL_W +: PL_W];
    end
  end

  // map second-rank losers back to their source index
  always_comb begin
    drop_d = '0;
    for (int s = 0; s < NODES; s++)
      if (s2_lose[s]) drop_d[s1_pl_q[s*PL_W + SRC_LSB +: IDX_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q    <= '0;
      last_r_q <= '0;
      s1_v_q   <= '0;
      out_v_q  <= '0;
      drop_q   <= '0;
    end else begin
      blk_q   <= s1_lose;
      s1_v_q  <= s1_v_d;
      out_v_q <= out_v_d;
      drop_q  <= drop_d;
      for (int i = 0; i < NODES; i++)
        if (in_valid[i]) last_r_q[i] <= r_pick[i];
    end
  end

  always_ff @(posedge clk) begin
    s1_pl_q  <= s1_pl_d;
    out_pl_q <= out_pl_d;
  end

  assign in_blocked = blk_q;
  assign out_valid  = out_v_q;
  assign out_drop   = drop_q;

  for (genvar j = 0; j < NODES; j++) begin : g_port
    assign out_data[j*DATA_W +: DATA_W] = out_pl_q[j*PL_W +: DATA_W];
    assign out_src[j*IDX_W +: IDX_W]    = out_pl_q[j*PL_W + SRC_LSB +: IDX_W];

    a_r2_dest_match: assert property (@(posedge clk) disable iff (rst)
      out_v_q[j] |-> (out_pl_q[j*PL_W + DST_LSB +: IDX_W] == IDX_W'(j)))
      else $error("R2: output %0d carries foreign destination", j);

    a_r4_blk_had_req: assert property (@(posedge clk) disable iff (rst)
      blk_q[j] |-> $past(in_valid[j]))
      else $error("R4: input %0d blocked without a request", j);
  end

  a_r3_conserve: assert property (@(posedge clk) disable iff (rst)
    ($countones(out_v_q) + $countones(drop_q)) == $past($countones(s1_v_q)))
    else $error("R3: packets created or lost between ranks");
endmodule

// File: tb/tb_mpn_net.sv
module tb_mpn_net;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0]    in_valid = '0, in_rsel_en = '0, in_rsel = '0;
  logic [23:0]   in_dest = '0;
  logic [8*DW-1:0] in_data = '0;
  logic [7:0]    in_blocked, out_valid, out_drop;
  logic [8*DW-1:0] out_data;
  logic [23:0]   out_src;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct { int kind; int at; int idx; int src; int data; string tag; } exp_t;
  exp_t q[$];

  mpn_net #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .in_rsel_en(in_rsel_en), .in_rsel(in_rsel), .in_blocked(in_blocked),
    .out_valid(out_valid), .out_data(out_data), .out_src(out_src), .out_drop(out_drop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // driver helpers: expectations are pushed as stimulus is applied
  task automatic put(input int i, input int d, input int data, input bit en, input bit r);
    in_valid[i] = 1'b1;
    in_dest[i*3 +: 3] = 3'(d);
    in_data[i*DW +: DW] = DW'(data);
    in_rsel_en[i] = en;
    in_rsel[i] = r;
  endtask
  task automatic exp_out(input int j, input int src, input int data, input string tag);
    exp_t e = '{0, cyc + 2, j, src, data, tag}; q.push_back(e);
  endtask
  task automatic exp_blk(input int i, input string tag);
    exp_t e = '{1, cyc + 1, i, 0, 0, tag}; q.push_back(e);
  endtask
  task automatic exp_drop(input int i, input string tag);
    exp_t e = '{2, cyc + 2, i, 0, 0, tag}; q.push_back(e);
  endtask
  task automatic next_cycle();
    @(negedge clk);
    in_valid = '0; in_rsel_en = '0; in_rsel = '0;
  endtask
  task automatic idle(input int n);
    repeat (n) next_cycle();
  endtask

  // monitor: pops the entries due this cycle and compares with the ports
  always @(negedge clk) begin
    if (!rst) begin
      logic [7:0] ev, eb, ed;
      ev = '0; eb = '0; ed = '0;
      for (int k = q.size() - 1; k >= 0; k--) begin
        if (q[k].at == cyc) begin
          case (q[k].kind)
            0: begin
              ev[q[k].idx] = 1'b1;
              chk(out_valid[q[k].idx] && out_src[q[k].idx*3 +: 3] == 3'(q[k].src) &&
                  out_data[q[k].idx*DW +: DW] == DW'(q[k].data),
                  {q[k].tag, " delivery"},
                  {out_valid[q[k].idx], 5'b0, out_src[q[k].idx*3 +: 3], out_data[q[k].idx*DW +: DW]},
                  {1'b1, 5'b0, 3'(q[k].src), DW'(q[k].data)});
            end
            1: eb[q[k].idx] = 1'b1;
            default: ed[q[k].idx] = 1'b1;
          endcase
          q.delete(k);
        end
      end
      if (ev != 0 || out_valid != 0) chk(out_valid == ev, "R3 out_valid mask", out_valid, ev);
      if (eb != 0 || in_blocked != 0) chk(in_blocked == eb, "R4 in_blocked mask", in_blocked, eb);
      if (ed != 0 || out_drop != 0) chk(out_drop == ed, "R6 out_drop mask", out_drop, ed);
    end
  end

  task automatic finish_run();
    chk(q.size() == 0, "R3 pending expectations", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 0 && in_blocked == 0 && out_drop == 0, "R1 reset outputs",
        {out_valid, in_blocked, out_drop}, 0);

    // R2: single packet, explicit path
    put(3, 6, 8'hA5, 1, 0); exp_out(6, 3, 8'hA5, "R2 single");
    idle(4);
    // R7: single packet, generator-chosen path
    put(5, 1, 8'h3C, 0, 0); exp_out(1, 5, 8'h3C, "R7 generator path");
    idle(4);

    // R2: identity permutation, path = i[0]
    for (int i = 0; i < 8; i++) begin put(i, i, 8'h10 + i, 1, i[0]); exp_out(i, i, 8'h10 + i, "R2 identity"); end
    idle(4);
    // R2: dest = i ^ 5, path = i[0]
    for (int i = 0; i < 8; i++) begin put(i, i ^ 5, 8'h80 + i, 1, i[0]); exp_out(i ^ 5, i, 8'h80 + i, "R2 swap"); end
    idle(4);

    // R4: inputs 1 and 2, same box, same d[1], same path -> input 1 wins
    put(1, 2, 8'h11, 1, 1); put(2, 6, 8'h22, 1, 1);
    exp_out(2, 1, 8'h11, "R4 winner"); exp_blk(2, "R4 loser");
    idle(4);
    // R5: same pair, different path -> both delivered
    put(1, 2, 8'h33, 1, 1); put(2, 6, 8'h44, 1, 0);
    exp_out(2, 1, 8'h33, "R5 path 1"); exp_out(6, 2, 8'h44, "R5 path 0");
    idle(4);

    // R6: same dest 5; input0 port {1,0}=2, input4 port {0,1}=1 -> input4 wins
    put(0, 5, 8'h55, 1, 1); put(4, 5, 8'h66, 1, 0);
    exp_out(5, 4, 8'h66, "R6 winner"); exp_drop(0, "R6 loser");
    idle(4);
    // R7: both path 0 -> input0 port 0 wins, input4 dropped
    put(0, 5, 8'h77, 1, 0); put(4, 5, 8'h88, 1, 0);
    exp_out(5, 0, 8'h77, "R7 explicit path"); exp_drop(4, "R7 explicit path loser");
    idle(4);

    // R8: input1 blocked with path 0, then retries unforced -> path 1
    put(0, 2, 8'h01, 1, 0); put(1, 6, 8'h02, 1, 0);
    exp_out(2, 0, 8'h01, "R8 setup winner"); exp_blk(1, "R8 setup loser");
    next_cycle();
    put(0, 3, 8'h03, 1, 0); put(1, 6, 8'h02, 0, 0); put(2, 7, 8'h04, 1, 1);
    exp_out(3, 0, 8'h03, "R8 bystander"); exp_out(6, 1, 8'h02, "R8 retry flipped");
    exp_blk(2, "R8 third input blocked by retry");
    idle(5);

    done = 1;
    finish_run();
  end
endmodule